// File: doc/BRIEF.md
# SPI Serial Memory Command Engine

This block is the slave side of a serial memory port. A host selects it by pulling the active-low select line low, then clocks in an 8-bit command, most significant bit first. Depending on the command, the engine collects a 24-bit address and streams bytes into or out of a byte-wide memory array. It also reads and writes a small status byte, sets and clears a write-enable latch, returns a fixed 32-bit identifier, and enters a low-power sleep state. Input bits are captured on rising serial-clock edges and output bits change on falling edges. Both idle-low and idle-high serial-clock polarities work (SPI modes 0 and 3).

The serial pins are oversampled in the block's own system clock domain. Any write into the array or the status byte goes ahead only if an external protection unit raises `prot_grant`. The engine shows that unit the current target address (`prot_addr`), whether the target is the status byte (`prot_status_wr`), and the status byte itself (`status_out`). The array is a behavioural register array. Its depth is a parameter, and it is smaller than the full 17-bit address space unless that parameter is raised.

Top module: `spi_mem_cmd_engine`

## Requirements
- R1: The engine accepts nine command bytes: 0x06 set write-enable, 0x04 clear write-enable, 0x05 read status, 0x01 write status, 0x03 read, 0x0B fast read, 0x02 write, 0x9F read identifier, and 0xB9 sleep. Any other byte is ignored until select next goes high, including later bytes in the same select period. During that period SO stays disabled.
- R2: While select is high, SO is disabled and serial clock and data have no effect. SO is also disabled while the command, address and dummy bits are being received.
- R3: If select rises before the eighth command bit, no command takes effect.
- R4: Read takes 24 address bits, most significant first. The top 7 bits are ignored. The first data bit is driven on the falling edge that follows the last address bit, and data is sent most significant bit first.
- R5: Fast read inserts 8 dummy clocks after the address. Data then starts on the next falling edge, with the same bit order as read.
- R6: Each further 8 clocks of a read or write move to the next address. After 0x1FFFF the address wraps to 0x00000.
- R7: A write byte reaches the array only when all 8 of its bits have been received. A partial byte at deselect is dropped.
- R8: A write byte is stored only if `prot_grant` is high when its eighth bit is captured. If the grant is low, the byte is discarded but the address still advances.
- R9: Read identifier sends the bytes 0x04, 0x7F, 0x27, 0x03 in that order. After the 32nd bit, SO keeps that bit's value (1) until deselect.
- R10: Read status returns the status byte and repeats it every 8 clocks. In the status byte, bits 7..2 are the stored bits, bit 1 is the write-enable latch, and bit 0 is always 0.
- R11: Command 0x06 sets the write-enable latch and 0x04 clears it. The latch is also cleared at the select rise that ends a select period in which 0x02 or 0x01 was decoded.
- R12: Write status stores data bits 7..2 only when `prot_grant` is high at the eighth data bit. Data bits 1 and 0 are ignored.
- R13: Sleep starts at the select rise that directly follows the sleep command, provided no further rising clock edge arrived after the command; any extra rising edge cancels the entry. While asleep, SO is disabled and all inputs are ignored. The engine wakes WAKE_CYCLES clocks after select falls, and the select period during which it wakes carries no command.
- R14: The same transactions work with the serial clock idling high (mode 3) as with it idling low (mode 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_cs_n | input | 1 | Active-low select |
| spi_sck | input | 1 | Serial clock |
| spi_si | input | 1 | Serial data in |
| spi_so | output | 1 | Serial data out |
| spi_so_oe | output | 1 | Output enable for SO; 0 means high impedance |
| prot_addr | output | ADDR_W | Current target address for the protection unit |
| prot_status_wr | output | 1 | High while a status write is being received |
| prot_grant | input | 1 | Protection unit permits the pending write |
| status_out | output | 8 | Status byte: bits 7..2 stored, bit 1 write-enable latch, bit 0 zero |
| asleep | output | 1 | High while in the sleep state |

## Verification
Most wrong internal states appear within one byte at the ports. A bit counter off by one misaligns the next data byte returned on SO. A wrong address register shows up as the wrong byte on a later read-back, which is why writes are always checked by reading the data back through the serial port. A stuck write-enable latch or status bit shows on `status_out` one clock after the select rise, and a read-status transaction shows it again on SO. Sleep and identifier-hold faults show as SO being enabled, or as a changing SO, in the very next bit period.

// File: rtl/spi_mem_pkg.sv
// Shared command codes, engine states and the identifier constant.
// Assumes: command bytes are sent MSB first.
package spi_mem_pkg;

    localparam logic [7:0] CMD_WEN_SET = 8'h06;
    localparam logic [7:0] CMD_WEN_CLR = 8'h04;
    localparam logic [7:0] CMD_SR_GET  = 8'h05;
    localparam logic [7:0] CMD_SR_PUT  = 8'h01;
    localparam logic [7:0] CMD_RD      = 8'h03;
    localparam logic [7:0] CMD_RD_FAST = 8'h0B;
    localparam logic [7:0] CMD_WR      = 8'h02;
    localparam logic [7:0] CMD_ID      = 8'h9F;
    localparam logic [7:0] CMD_NAP     = 8'hB9;

    localparam int ADDR_FIELD_BITS = 24;
    localparam int ID_BYTES        = 4;

    typedef enum logic [3:0] {
        ST_CMD,     // receiving the command byte
        ST_ADR,     // receiving the 24-bit address
        ST_PAD,     // fast-read dummy clocks
        ST_RD,      // streaming array bytes out
        ST_WR,      // streaming array bytes in
        ST_SR_RD,   // repeating the status byte out
        ST_SR_WR,   // receiving the status byte
        ST_ID,      // shifting out the identifier
        ST_NAP_ARM, // sleep command seen, waiting for deselect
        ST_MUTE     // ignore everything until deselect
    } eng_state_t;

    // Identifier byte for a given index, first byte sent first.
    function automatic logic [7:0] id_byte(input logic [1:0] idx);
        case (idx)
            2'd0:    id_byte = 8'h04;
            2'd1:    id_byte = 8'h7F;
            2'd2:    id_byte = 8'h27;
            default: id_byte = 8'h03;
        endcase
    endfunction

endpackage

// File: rtl/spi_mem_sampler.sv
// Brings the serial pins into the clk domain through a SYNC_STAGES flop chain.
// Produces one-cycle edge pulses. Clock edges are reported only while select is low.
// Assumes: each serial clock phase lasts at least SYNC_STAGES+2 clk cycles.
module spi_mem_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_raw,
    input  logic sck_raw,
    input  logic si_raw,
    output logic cs_s,
    output logic si_s,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_rise,
    output logic cs_fall
);

    localparam int LAST = SYNC_STAGES - 1;

    logic [2:0] pipe_q [SYNC_STAGES];
    logic       sck_prev_q;
    logic       cs_prev_q;
    logic       sck_s;

    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
        if (i == 0) begin : g_first
            // Capture the raw pins, {select, clock, data}.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe_q[i] <= 3'b100;
                else        pipe_q[i] <= {cs_n_raw, sck_raw, si_raw};
            end
        end else begin : g_next
            // Pass the sample one stage further.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe_q[i] <= 3'b100;
                else        pipe_q[i] <= pipe_q[i-1];
            end
        end
    end

    assign cs_s  = pipe_q[LAST][2];
    assign sck_s = pipe_q[LAST][1];
    assign si_s  = pipe_q[LAST][0];

    // Remember the previous synchronised levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_prev_q <= 1'b0;
            cs_prev_q  <= 1'b1;
        end else begin
            sck_prev_q <= sck_s;
            cs_prev_q  <= cs_s;
        end
    end

    assign sck_rise = ~cs_s & sck_s & ~sck_prev_q;
    assign sck_fall = ~cs_s & ~sck_s & sck_prev_q;
    assign cs_rise  = cs_s & ~cs_prev_q;
    assign cs_fall  = ~cs_s & cs_prev_q;

endmodule

// File: rtl/spi_mem_array.sv
// Behavioural byte array: one synchronous write port and one combinational read port.
// Assumes: the address is already truncated to AW bits.
module spi_mem_array #(
    parameter int AW = 10,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    // Clear the array on reset and store a byte on each write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

    // R7: a strobed byte is present at its address on the next cycle
    assert_write_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> mem_q[$past(waddr)] == $past(wdata));

endmodule

// File: rtl/spi_mem_status.sv
// Status byte: six stored bits, the write-enable latch, and a zero in bit 0.
// Assumes: if set and clear arrive in the same cycle, set wins.
module spi_mem_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_wel,
    input  logic       clr_wel,
    input  logic       nv_we,
    input  logic [5:0] nv_wdata,
    output logic [7:0] status
);

    logic       wel_q;
    logic [5:0] nv_q;

    // Update the write-enable latch and the stored bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel_q <= 1'b0;
            nv_q  <= '0;
        end else begin
            if (set_wel)      wel_q <= 1'b1;
            else if (clr_wel) wel_q <= 1'b0;
            if (nv_we)        nv_q  <= nv_wdata;
        end
    end

    assign status = {nv_q, wel_q, 1'b0};

    // R11: a clear request without a set leaves the latch low
    assert_wel_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wel && !set_wel) |=> !status[1]);

endmodule

// File: rtl/spi_mem_cmd_engine.sv
// Serial memory command engine (slave). Decodes a command byte, collects a
// 24-bit address, and streams array bytes, the status byte or the identifier.
// Assumes: serial pins are slow relative to clk (see spi_mem_sampler), and
// prot_grant is valid during the cycle in which the eighth data bit is captured.
module spi_mem_cmd_engine
    import spi_mem_pkg::*;
#(
    parameter int ADDR_W      = 17,
    parameter int ARRAY_AW    = 10,
    parameter int SYNC_STAGES = 2,
    parameter int WAKE_CYCLES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_cs_n,
    input  logic              spi_sck,
    input  logic              spi_si,
    output logic              spi_so,
    output logic              spi_so_oe,
    output logic [ADDR_W-1:0] prot_addr,
    output logic              prot_status_wr,
    input  logic              prot_grant,
    output logic [7:0]        status_out,
    output logic              asleep
);

    localparam int WAKE_W    = $clog2(WAKE_CYCLES + 1);
    localparam int ADR_LAST  = ADDR_FIELD_BITS - 1;
    localparam int CNT_W     = $clog2(ADDR_FIELD_BITS);

    logic cs_s, si_s, sck_rise, sck_fall, cs_rise, cs_fall;

    spi_mem_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n_raw (spi_cs_n),
        .sck_raw  (spi_sck),
        .si_raw   (spi_si),
        .cs_s     (cs_s),
        .si_s     (si_s),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .cs_rise  (cs_rise),
        .cs_fall  (cs_fall)
    );

    eng_state_t        state_q;
    logic [CNT_W-1:0]  bit_cnt_q;
    logic [6:0]        in_sh_q;
    logic [7:0]        cmd_q;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        out_sh_q;
    logic [2:0]        out_cnt_q;
    logic [2:0]        id_idx_q;
    logic              so_q, oe_q;
    logic              clr_pend_q, asleep_q, waking_q;
    logic [WAKE_W-1:0] wake_cnt_q;

    logic       rise_a, fall_a, byte_end, decode_now;
    logic [7:0] in_byte, src_byte, mem_rdata, status_w;
    logic       set_wel, clr_wel, wr_commit, mem_we, nv_we, addr_step, id_hold;

    assign rise_a     = sck_rise & ~asleep_q;
    assign fall_a     = sck_fall & ~asleep_q;
    assign in_byte    = {in_sh_q, si_s};
    assign byte_end   = (bit_cnt_q[2:0] == 3'd7);
    assign decode_now = rise_a && state_q == ST_CMD && byte_end;
    assign set_wel    = decode_now && in_byte == CMD_WEN_SET;
    assign clr_wel    = (decode_now && in_byte == CMD_WEN_CLR) ||
                        (cs_rise && clr_pend_q && !asleep_q);
    assign wr_commit  = rise_a && state_q == ST_WR && byte_end;
    assign mem_we     = wr_commit & prot_grant;
    assign nv_we      = rise_a && state_q == ST_SR_WR && byte_end && prot_grant;
    assign id_hold    = state_q == ST_ID && id_idx_q == 3'(ID_BYTES);
    assign addr_step  = wr_commit || (fall_a && state_q == ST_RD && out_cnt_q == 3'd0);

    // Pick the byte that starts the next output group.
    always_comb begin
        case (state_q)
            ST_RD:    src_byte = mem_rdata;
            ST_SR_RD: src_byte = status_w;
            ST_ID:    src_byte = id_byte(id_idx_q[1:0]);
            default:  src_byte = 8'h00;
        endcase
    end

    spi_mem_array #(.AW(ARRAY_AW), .DW(8)) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (addr_q[ARRAY_AW-1:0]),
        .wdata (in_byte),
        .raddr (addr_q[ARRAY_AW-1:0]),
        .rdata (mem_rdata)
    );

    spi_mem_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_wel  (set_wel),
        .clr_wel  (clr_wel),
        .nv_we    (nv_we),
        .nv_wdata (in_byte[7:2]),
        .status   (status_w)
    );

    // Command sequencer: sleep handling, deselect reset, rise-edge input, fall-edge output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_CMD;
            bit_cnt_q  <= '0;
            in_sh_q    <= '0;
            cmd_q      <= '0;
            addr_q     <= '0;
            out_sh_q   <= '0;
            out_cnt_q  <= '0;
            id_idx_q   <= '0;
            so_q       <= 1'b0;
            oe_q       <= 1'b0;
            clr_pend_q <= 1'b0;
            asleep_q   <= 1'b0;
            waking_q   <= 1'b0;
            wake_cnt_q <= '0;
        end else if (asleep_q) begin
            if (waking_q) begin
                wake_cnt_q <= wake_cnt_q - 1'b1;
                if (wake_cnt_q == WAKE_W'(1)) begin
                    asleep_q <= 1'b0;
                    waking_q <= 1'b0;
                    state_q  <= ST_MUTE;
                end
            end else if (cs_fall) begin
                waking_q   <= 1'b1;
                wake_cnt_q <= WAKE_W'(WAKE_CYCLES);
            end
        end else if (cs_s) begin
            state_q    <= ST_CMD;
            bit_cnt_q  <= '0;
            out_cnt_q  <= '0;
            id_idx_q   <= '0;
            oe_q       <= 1'b0;
            clr_pend_q <= 1'b0;
            if (cs_rise && state_q == ST_NAP_ARM) asleep_q <= 1'b1;
        end else if (rise_a) begin
            bit_cnt_q <= bit_cnt_q + 1'b1;
            in_sh_q   <= in_byte[6:0];
            case (state_q)
                ST_CMD: if (byte_end) begin
                    bit_cnt_q <= '0;
                    cmd_q     <= in_byte;
                    case (in_byte)
                        CMD_SR_GET: begin state_q <= ST_SR_RD; oe_q <= 1'b1; end
                        CMD_SR_PUT: begin state_q <= ST_SR_WR; clr_pend_q <= 1'b1; end
                        CMD_RD, CMD_RD_FAST: state_q <= ST_ADR;
                        CMD_WR:     begin state_q <= ST_ADR; clr_pend_q <= 1'b1; end
                        CMD_ID:     begin state_q <= ST_ID; oe_q <= 1'b1; end
                        CMD_NAP:    state_q <= ST_NAP_ARM;
                        default:    state_q <= ST_MUTE;
                    endcase
                end
                ST_ADR: begin
                    addr_q <= {addr_q[ADDR_W-2:0], si_s};
                    if (bit_cnt_q == CNT_W'(ADR_LAST)) begin
                        bit_cnt_q <= '0;
                        if (cmd_q == CMD_WR)           state_q <= ST_WR;
                        else if (cmd_q == CMD_RD_FAST) state_q <= ST_PAD;
                        else begin state_q <= ST_RD; oe_q <= 1'b1; end
                    end
                end
                ST_PAD: if (byte_end) begin
                    bit_cnt_q <= '0;
                    state_q   <= ST_RD;
                    oe_q      <= 1'b1;
                end
                ST_WR: if (byte_end) begin
                    bit_cnt_q <= '0;
                    addr_q    <= addr_q + 1'b1;
                end
                ST_SR_WR:   if (byte_end) state_q <= ST_MUTE;
                ST_NAP_ARM: state_q <= ST_MUTE;
                default:    bit_cnt_q <= '0;
            endcase
        end else if (fall_a && (state_q == ST_RD || state_q == ST_SR_RD || state_q == ST_ID)) begin
            if (out_cnt_q == 3'd0) begin
                if (!id_hold) begin
                    so_q      <= src_byte[7];
                    out_sh_q  <= {src_byte[6:0], 1'b0};
                    out_cnt_q <= 3'd1;
                    if (state_q == ST_ID) id_idx_q <= id_idx_q + 1'b1;
                    if (state_q == ST_RD) addr_q   <= addr_q + 1'b1;
                end
            end else begin
                so_q      <= out_sh_q[7];
                out_sh_q  <= {out_sh_q[6:0], 1'b0};
                out_cnt_q <= out_cnt_q + 1'b1;
            end
        end
    end

    assign spi_so         = so_q;
    assign spi_so_oe      = oe_q;
    assign prot_addr      = addr_q;
    assign prot_status_wr = (state_q == ST_SR_WR);
    assign status_out     = status_w;
    assign asleep         = asleep_q;

    // R2: a deselected port releases SO by the next cycle
    assert_so_released_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> !oe_q);

    // R13: SO is never enabled while asleep
    assert_sleep_silent_R13: assert property (@(posedge clk) disable iff (!rst_n)
        asleep_q |-> !oe_q);

    // R6: stepping past the top address lands on zero
    assert_addr_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_step && addr_q == {ADDR_W{1'b1}}) |=> addr_q == '0);

    // R9: once all identifier bits are out, SO holds its value
    assert_id_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (id_hold && out_cnt_q == 3'd0) |=> $stable(so_q));

endmodule

// File: tb/sim_spi_mem_cmd_engine.sv
module sim_spi_mem_cmd_engine;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;
    localparam int WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sck = 1'b0;
    logic        si = 1'b0;
    logic        grant = 1'b0;
    logic        so, so_oe, prot_sr, sleep_o;
    logic [16:0] prot_addr;
    logic [7:0]  status;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    logic done = 1'b0;
    logic mode3 = 1'b0;

    spi_mem_cmd_engine u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .spi_cs_n       (cs_n),
        .spi_sck        (sck),
        .spi_si         (si),
        .spi_so         (so),
        .spi_so_oe      (so_oe),
        .prot_addr      (prot_addr),
        .prot_status_wr (prot_sr),
        .prot_grant     (grant),
        .status_out     (status),
        .asleep         (sleep_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WATCHDOG && !done) begin
            n_chk  = n_chk + 1;
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual %0d expected <%0d cycles", cyc, WATCHDOG);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic xbit(input logic b, output logic rb, output logic roe);
        if (mode3) sck = 1'b0;
        si = b;
        repeat (HALF) @(negedge clk);
        rb  = so;
        roe = so_oe;
        sck = 1'b1;
        repeat (HALF) @(negedge clk);
        if (!mode3) sck = 1'b0;
    endtask

    task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx, output logic oe_all, output logic oe_any);
        logic rb, roe;
        oe_all = 1'b1;
        oe_any = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            xbit(tx[i], rb, roe);
            rx[i]  = rb;
            oe_all = oe_all & roe;
            oe_any = oe_any | roe;
        end
    endtask

    task automatic cs_on(input logic m);
        mode3 = m;
        sck = m;
        repeat (2) @(negedge clk);
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic cs_off();
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (4*HALF) @(negedge clk);
    endtask

    task automatic cmd_only(input logic [7:0] op, output logic oe_any);
        logic [7:0] rx;
        logic oa;
        cs_on(1'b0);
        xbyte(op, rx, oa, oe_any);
        cs_off();
    endtask

    task automatic send_adr(input logic [7:0] op, input logic [23:0] a, output logic oe_any);
        logic [7:0] rx;
        logic oa, on;
        xbyte(op, rx, oa, oe_any);
        for (int k = 0; k < 3; k++) begin
            xbyte(a[23-8*k -: 8], rx, oa, on);
            oe_any = oe_any | on;
        end
    endtask

    task automatic wr_stream(input logic m, input logic [23:0] a, input int n,
                             input logic [23:0] d, input logic [2:0] g);
        logic [7:0] rx;
        logic oa, on;
        cs_on(m);
        send_adr(8'h02, a, on);
        for (int i = 0; i < n; i++) begin
            grant = g[2-i];
            xbyte(d[23-8*i -: 8], rx, oa, on);
        end
        grant = 1'b0;
        cs_off();
    endtask

    task automatic rd_stream(input logic fast, input logic m, input logic [23:0] a, input int n,
                             output logic [23:0] got, output logic oe_ok, output logic pre_oe);
        logic [7:0] rx;
        logic oa, on;
        got = '0;
        oe_ok = 1'b1;
        cs_on(m);
        send_adr(fast ? 8'h0B : 8'h03, a, pre_oe);
        if (fast) begin
            xbyte(8'h00, rx, oa, on);
            pre_oe = pre_oe | on;
        end
        for (int i = 0; i < n; i++) begin
            xbyte(8'h00, rx, oa, on);
            got   = {got[15:0], rx};
            oe_ok = oe_ok & oa;
        end
        cs_off();
    endtask

    // {is_write, grant, address[23:0], data-or-expected[7:0]}
    localparam logic [33:0] VEC [8] = '{
        {1'b1, 1'b1, 24'h000010, 8'hA5},
        {1'b1, 1'b1, 24'hFE0011, 8'h3C},
        {1'b0, 1'b0, 24'h000010, 8'hA5},
        {1'b0, 1'b0, 24'h000011, 8'h3C},
        {1'b1, 1'b0, 24'h000012, 8'h77},
        {1'b0, 1'b0, 24'h000012, 8'h00},
        {1'b1, 1'b1, 24'h01FFF0, 8'h5A},
        {1'b0, 1'b0, 24'hFFFFF0, 8'h5A}
    };

    initial begin
        logic [23:0] got;
        logic [7:0]  rx;
        logic        ok, pre, oa, on, rb, roe;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R2 reset so_oe", {31'd0, so_oe}, 32'd0);
        chk("R11 reset status", {24'd0, status}, 32'd0);
        chk("R13 reset asleep", {31'd0, sleep_o}, 32'd0);

        // Table walk: writes with and without grant, read-back (R4, R8)
        for (int k = 0; k < 8; k++) begin
            if (VEC[k][33]) begin
                wr_stream(1'b0, VEC[k][31:8], 1, {VEC[k][7:0], 16'h0}, {VEC[k][32], 2'b00});
            end else begin
                rd_stream(1'b0, 1'b0, VEC[k][31:8], 1, got, ok, pre);
                chk("R4 R8 vector read", {24'd0, got[7:0]}, {24'd0, VEC[k][7:0]});
                chk("R2 no SO during header", {31'd0, pre}, 32'd0);
            end
        end

        // R2: activity while deselected is ignored
        for (int i = 7; i >= 0; i--) xbit(CMD_BITS_WEN[i], rb, roe);
        repeat (4*HALF) @(negedge clk);
        chk("R2 deselected clocks ignored", {24'd0, status}, 32'd0);
        chk("R2 SO off deselected", {31'd0, so_oe}, 32'd0);

        // R3: seven command bits then deselect
        cs_on(1'b0);
        for (int i = 7; i >= 1; i--) xbit(CMD_BITS_WEN[i], rb, roe);
        cs_off();
        chk("R3 truncated command", {24'd0, status}, 32'd0);

        // R1: unknown command mutes the rest of the select period
        cs_on(1'b0);
        xbyte(8'hAB, rx, oa, on);
        xbyte(8'h06, rx, oa, pre);
        xbyte(8'h00, rx, oa, ok);
        cs_off();
        chk("R1 unknown command ignored", {24'd0, status}, 32'd0);
        chk("R1 SO off after unknown", {31'd0, on | pre | ok}, 32'd0);

        // R11, R10: latch set/clear and repeated status read
        cmd_only(8'h06, on);
        chk("R11 set latch", {24'd0, status}, 32'h02);
        cs_on(1'b0);
        xbyte(8'h05, rx, oa, on);
        xbyte(8'h00, rx, oa, ok);
        chk("R10 status byte 1", {24'd0, rx}, 32'h02);
        xbyte(8'h00, rx, oa, ok);
        chk("R10 status byte 2", {24'd0, rx}, 32'h02);
        chk("R10 SO enabled", {31'd0, oa}, 32'd1);
        cs_off();
        cmd_only(8'h04, on);
        chk("R11 clear latch", {24'd0, status}, 32'h00);
        cmd_only(8'h06, on);
        cmd_only(8'h02, on);
        chk("R11 latch cleared after write command", {24'd0, status}, 32'h00);

        // R12: status write with grant, without grant, low bits ignored
        cmd_only(8'h06, on);
        cs_on(1'b0);
        xbyte(8'h01, rx, oa, on);
        grant = 1'b1;
        xbyte(8'hFF, rx, oa, on);
        grant = 1'b0;
        cs_off();
        chk("R12 status write granted", {24'd0, status}, 32'hFC);
        cs_on(1'b0);
        xbyte(8'h01, rx, oa, on);
        xbyte(8'h00, rx, oa, on);
        cs_off();
        chk("R12 status write denied", {24'd0, status}, 32'hFC);
        cs_on(1'b0);
        xbyte(8'h01, rx, oa, on);
        grant = 1'b1;
        xbyte(8'h03, rx, oa, on);
        grant = 1'b0;
        cs_off();
        chk("R12 low bits ignored", {24'd0, status}, 32'h00);

        // R6: streaming write across the top address and read-back
        wr_stream(1'b0, 24'h01FFFF, 3, 24'h112233, 3'b111);
        rd_stream(1'b0, 1'b0, 24'h000000, 2, got, ok, pre);
        chk("R6 wrap lands at zero", {8'd0, got}, {8'd0, 8'h00, 16'h2233});
        rd_stream(1'b0, 1'b0, 24'h01FFFF, 3, got, ok, pre);
        chk("R6 read wrap stream", {8'd0, got}, {8'd0, 24'h112233});

        // R8: denied byte still advances the address
        wr_stream(1'b0, 24'h000040, 2, 24'h996600, 3'b010);
        rd_stream(1'b0, 1'b0, 24'h000040, 2, got, ok, pre);
        chk("R8 deny then grant", {16'd0, got[15:0]}, 32'h0066);

        // R7: partial byte dropped
        cs_on(1'b0);
        send_adr(8'h02, 24'h000020, on);
        grant = 1'b1;
        for (int i = 0; i < 5; i++) xbit(1'b1, rb, roe);
        cs_off();
        grant = 1'b0;
        rd_stream(1'b0, 1'b0, 24'h000020, 1, got, ok, pre);
        chk("R7 partial byte dropped", {24'd0, got[7:0]}, 32'h00);

        // R5: fast read with dummy byte
        rd_stream(1'b1, 1'b0, 24'h000010, 2, got, ok, pre);
        chk("R5 fast read data", {16'd0, got[15:0]}, 32'hA53C);
        chk("R5 SO off through dummy", {31'd0, pre}, 32'd0);
        chk("R5 SO on during data", {31'd0, ok}, 32'd1);

        // R14: mode 3 read and write
        rd_stream(1'b0, 1'b1, 24'h000010, 2, got, ok, pre);
        chk("R14 mode3 read", {16'd0, got[15:0]}, 32'hA53C);
        wr_stream(1'b1, 24'h000050, 1, 24'hC30000, 3'b100);
        rd_stream(1'b0, 1'b0, 24'h000050, 1, got, ok, pre);
        chk("R14 mode3 write", {24'd0, got[7:0]}, 32'hC3);

        // R9: identifier and held last bit
        cs_on(1'b0);
        xbyte(8'h9F, rx, oa, on);
        got = '0;
        for (int i = 0; i < 3; i++) begin
            xbyte(8'h00, rx, oa, on);
            got = {got[15:0], rx};
        end
        chk("R9 id bytes 0..2", {8'd0, got}, 32'h00047F27);
        xbyte(8'h00, rx, oa, on);
        chk("R9 id byte 3", {24'd0, rx}, 32'h03);
        xbyte(8'h00, rx, oa, on);
        chk("R9 last bit held", {24'd0, rx}, 32'hFF);
        chk("R9 SO still enabled", {31'd0, oa}, 32'd1);
        cs_off();

        // R13: sleep entry, ignored wake period, then normal
        cmd_only(8'hB9, on);
        chk("R13 asleep after command", {31'd0, sleep_o}, 32'd1);
        chk("R13 SO off asleep", {31'd0, so_oe}, 32'd0);
        cs_on(1'b0);
        repeat (10) @(negedge clk);
        chk("R13 still asleep during recovery", {31'd0, sleep_o}, 32'd1);
        xbyte(8'h06, rx, oa, on);
        cs_off();
        chk("R13 awake after recovery", {31'd0, sleep_o}, 32'd0);
        chk("R13 waking period carries no command", {24'd0, status}, 32'h00);
        cmd_only(8'h06, on);
        chk("R13 normal after wake", {24'd0, status}, 32'h02);
        cs_on(1'b0);
        xbyte(8'hB9, rx, oa, on);
        xbit(1'b0, rb, roe);
        cs_off();
        chk("R13 extra clock cancels sleep", {31'd0, sleep_o}, 32'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    localparam logic [7:0] CMD_BITS_WEN = 8'h06;

endmodule